// File: doc/BRIEF.md
# External Bus Lending Arbiter

This block decides who drives the external memory bus: the chip itself, or a slave device outside the chip that borrows the bus. The outside device raises a request line. Once the request has held long enough and the chip has no work of its own pending, the block raises an acknowledge line. At the same edge it drops a single output-enable that covers the address, chip-select, read/write, read strobe, write strobe, data and bus-start pads. When the device lets go of its request, the block takes the bus back at once.

Two kinds of on-chip work compete for the bus while it is owned: a memory refresh and a set of internal bus masters. Each uses a simple request/done handshake. A refresh request can force the bus back from the borrower even while the borrower still asks for it: the acknowledge is dropped, and the pads stay floating until the borrower releases. Internal master requests never force the bus back. They wait. After a refresh-driven recovery they run back-to-back after the refresh, before the bus can be lent again.

Top module: `bus_lend_arb`

## Requirements
- R1: The acknowledge `ack_o` rises only after `ext_req_i` has been sampled high on two consecutive rising edges. A single-cycle request pulse never produces an acknowledge.
- R2: While `ack_o` is 1, `bus_oe_o` is 0, so all bus pads are high-impedance. No grant is active while the bus is lent.
- R3: When `ext_req_i` is sampled low while the bus is lent, then after that same edge `ack_o` is 0 and `bus_oe_o` is 1.
- R4: No refresh or master grant is active in the first cycle in which the pads are driven again. A pending access is granted at the next edge.
- R5: A refresh request sampled while the bus is lent drops `ack_o` at the next edge, even with `ext_req_i` still high. `bus_oe_o` stays 0 until `ext_req_i` is sampled low.
- R6: A master request made while the bus is lent has no effect: `ack_o` stays 1 and no grant appears.
- R7: After a refresh-driven recovery, the refresh is granted first. Every pending master then runs back-to-back, and only after that can the bus be lent again, even if `ext_req_i` is re-raised at once.
- R8: While the bus is owned and idle, the priority order is refresh, then masters (lowest index `mst_req_i` bit first), then the external request.
- R9: After reset, `ack_o` is 0, `bus_oe_o` is 1 and no grant is active.
- R10: `mst_grant_o` is one-hot or zero, and it never coexists with `refresh_grant_o`. A grant holds until its done pulse (`acc_done_i` or `refresh_done_i`). When several masters are pending, each done pulse moves the grant directly to the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ext_req_i | input | 1 | Bus request from the outside slave |
| refresh_req_i | input | 1 | Refresh wanted; held until done |
| refresh_done_i | input | 1 | One-cycle pulse ending the refresh |
| mst_req_i | input | N_MST | Per-master access request, held until served |
| acc_done_i | input | 1 | One-cycle pulse ending the granted master access |
| ack_o | output | 1 | Bus acknowledge to the outside slave |
| bus_oe_o | output | 1 | Drive enable for address, control, strobe, data and bus-start pads |
| refresh_grant_o | output | 1 | Refresh may use the bus |
| mst_grant_o | output | N_MST | One-hot master access grant |

## Verification
The bench sends a one-cycle request pulse; a design that counted edges loosely would lend the bus on it. It raises a refresh while the bus is lent and the request stays high; a design that waited for the slave would never drop the acknowledge, and one that drove the pads early would fight the slave. It queues masters during a lease and re-raises the request right after recovery; a wrong priority would lend the bus before the queued work runs. It also checks that the cycle in which the pads come back carries no grant, since an early grant would start an access before the bus settles.

// File: rtl/bus_lend_pkg.sv
package bus_lend_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ACCESS  = 3'd1,
        ST_REFRESH = 3'd2,
        ST_LENT    = 3'd3,
        ST_RECLAIM = 3'd4,
        ST_RECOVER = 3'd5
    } lend_state_e;

    typedef struct packed {
        logic ack;
        logic oe;
        logic rfsh;
        logic acc;
    } lend_out_t;

    function automatic lend_out_t lend_decode(lend_state_e s);
        lend_out_t o;
        o.ack  = (s == ST_LENT);
        o.oe   = (s == ST_IDLE) || (s == ST_ACCESS) ||
                 (s == ST_REFRESH) || (s == ST_RECOVER);
        o.rfsh = (s == ST_REFRESH);
        o.acc  = (s == ST_ACCESS);
        return o;
    endfunction

endpackage

// File: rtl/bus_lend_req_filter.sv
module bus_lend_req_filter #(
    parameter int HOLD_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    output logic qual_o
);
    localparam int CW = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYC - 1);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || !req_i) begin
            run_q <= '0;
        end else if (run_q < LIMIT) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign qual_o = req_i && (run_q >= LIMIT);
endmodule

// File: rtl/bus_lend_mst_sel.sv
module bus_lend_mst_sel #(
    parameter int N_MST = 4
) (
    input  logic [N_MST-1:0] req_i,
    output logic             any_o,
    output logic [N_MST-1:0] pick_o
);
    logic [N_MST:0] seen;
    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N_MST; i++) begin : g_chain
        assign pick_o[i]   = req_i[i] & ~seen[i];
        assign seen[i+1]   = seen[i] | req_i[i];
    end

    assign any_o = seen[N_MST];
endmodule

// File: rtl/bus_lend_arb.sv
module bus_lend_arb
    import bus_lend_pkg::*;
#(
    parameter int N_MST    = 4,
    parameter int HOLD_CYC = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_req_i,
    input  logic             refresh_req_i,
    input  logic             refresh_done_i,
    input  logic [N_MST-1:0] mst_req_i,
    input  logic             acc_done_i,
    output logic             ack_o,
    output logic             bus_oe_o,
    output logic             refresh_grant_o,
    output logic [N_MST-1:0] mst_grant_o
);
    lend_state_e      state_q, state_d;
    logic [N_MST-1:0] grant_q, grant_d;
    logic             ext_ok;
    logic             mst_any;
    logic [N_MST-1:0] mst_pick;
    lend_out_t        outs;

    bus_lend_req_filter #(.HOLD_CYC(HOLD_CYC)) u_filt (
        .clk    (clk),
        .rst    (rst),
        .req_i  (ext_req_i),
        .qual_o (ext_ok)
    );

    bus_lend_mst_sel #(.N_MST(N_MST)) u_sel (
        .req_i  (mst_req_i),
        .any_o  (mst_any),
        .pick_o (mst_pick)
    );

    always_comb begin
        state_d = state_q;
        grant_d = grant_q;
        unique case (state_q)
            ST_IDLE: begin
                if (refresh_req_i) begin
                    state_d = ST_REFRESH;
                end else if (mst_any) begin
                    state_d = ST_ACCESS;
                    grant_d = mst_pick;
                end else if (ext_ok) begin
                    state_d = ST_LENT;
                end
            end
            ST_ACCESS: begin
                if (acc_done_i) begin
                    if (refresh_req_i) begin
                        state_d = ST_REFRESH;
                    end else if (mst_any) begin
                        grant_d = mst_pick;
                    end else if (ext_ok) begin
                        state_d = ST_LENT;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_REFRESH: begin
                if (refresh_done_i) begin
                    if (mst_any) begin
                        state_d = ST_ACCESS;
                        grant_d = mst_pick;
                    end else if (ext_ok) begin
                        state_d = ST_LENT;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_LENT: begin
                if (!ext_req_i) begin
                    state_d = ST_RECOVER;
                end else if (refresh_req_i) begin
                    state_d = ST_RECLAIM;
                end
            end
            ST_RECLAIM: begin
                if (!ext_req_i) begin
                    state_d = ST_RECOVER;
                end
            end
            ST_RECOVER: begin
                if (refresh_req_i) begin
                    state_d = ST_REFRESH;
                end else if (mst_any) begin
                    state_d = ST_ACCESS;
                    grant_d = mst_pick;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            grant_q <= '0;
        end else begin
            state_q <= state_d;
            grant_q <= grant_d;
        end
    end

    assign outs            = lend_decode(state_q);
    assign ack_o           = outs.ack;
    assign bus_oe_o        = outs.oe;
    assign refresh_grant_o = outs.rfsh;
    assign mst_grant_o     = outs.acc ? grant_q : '0;
endmodule

// File: rtl/bus_lend_arb_chk.sv
module bus_lend_arb_chk #(
    parameter int N_MST = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             ext_req_i,
    input logic             refresh_req_i,
    input logic             refresh_done_i,
    input logic [N_MST-1:0] mst_req_i,
    input logic             ack_o,
    input logic             bus_oe_o,
    input logic             refresh_grant_o,
    input logic [N_MST-1:0] mst_grant_o
);
    // R1
    ack_two_sample_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_o) |-> ($past(ext_req_i) && $past(ext_req_i, 2)));

    // R2
    lent_floats_chk: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> (!bus_oe_o && !refresh_grant_o && mst_grant_o == '0));

    // R3
    release_return_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_o && !ext_req_i) |=> (!ack_o && bus_oe_o));

    // R4
    settle_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_oe_o) |-> (!refresh_grant_o && mst_grant_o == '0));

    // R5
    reclaim_float_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_o && ext_req_i && refresh_req_i) |=> (!ack_o && !bus_oe_o));

    // R6
    lent_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_o && ext_req_i && !refresh_req_i) |=> ack_o);

    // R7
    refresh_then_mst_chk: assert property (@(posedge clk) disable iff (rst)
        (refresh_grant_o && refresh_done_i && mst_req_i != '0) |=> (mst_grant_o != '0));

    // R10
    grant_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mst_grant_o) && !(refresh_grant_o && mst_grant_o != '0));
endmodule

bind bus_lend_arb bus_lend_arb_chk #(.N_MST(N_MST)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .ext_req_i       (ext_req_i),
    .refresh_req_i   (refresh_req_i),
    .refresh_done_i  (refresh_done_i),
    .mst_req_i       (mst_req_i),
    .ack_o           (ack_o),
    .bus_oe_o        (bus_oe_o),
    .refresh_grant_o (refresh_grant_o),
    .mst_grant_o     (mst_grant_o)
);

// File: tb/bus_lend_arb_tb.sv
module bus_lend_arb_tb;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ext_req = 1'b0;
    logic         rf_req = 1'b0;
    logic         rf_done = 1'b0;
    logic [N-1:0] mreq = '0;
    logic         adone = 1'b0;
    logic         ack, oe, rgnt;
    logic [N-1:0] mgnt;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    bus_lend_arb #(.N_MST(N), .HOLD_CYC(2)) u_dut (
        .clk             (clk),
        .rst             (rst),
        .ext_req_i       (ext_req),
        .refresh_req_i   (rf_req),
        .refresh_done_i  (rf_done),
        .mst_req_i       (mreq),
        .acc_done_i      (adone),
        .ack_o           (ack),
        .bus_oe_o        (oe),
        .refresh_grant_o (rgnt),
        .mst_grant_o     (mgnt)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // {ack, oe, rgnt, mgnt}
    task automatic chk_all(input string tag, input logic a, input logic o,
                           input logic r, input logic [N-1:0] g);
        chk(tag, {ack, oe, rgnt, mgnt}, {a, o, r, g});
    endtask

    task automatic lend_bus();
        ext_req = 1'b1;
        tick();
        tick();
        chk_all("R1 lent after two samples", 1, 0, 0, '0);
    endtask

    task automatic t_reset();
        chk_all("R9 reset state", 0, 1, 0, '0);
    endtask

    task automatic t_pulse();
        ext_req = 1'b1;
        tick();
        chk_all("R1 one sample only", 0, 1, 0, '0);
        ext_req = 1'b0;
        tick();
        chk_all("R1 pulse ignored", 0, 1, 0, '0);
        tick();
    endtask

    task automatic t_lend_mst_ignored();
        lend_bus();
        mreq = 4'b0001;
        tick();
        chk_all("R6 master while lent a", 1, 0, 0, '0);
        tick();
        tick();
        chk_all("R2 R6 master while lent b", 1, 0, 0, '0);
        ext_req = 1'b0;
        tick();
        chk_all("R3 R4 recover cycle", 0, 1, 0, '0);
        tick();
        chk_all("R4 access next edge", 0, 1, 0, 4'b0001);
        tick();
        chk_all("R10 grant held", 0, 1, 0, 4'b0001);
        adone = 1'b1;
        mreq = '0;
        tick();
        adone = 1'b0;
        chk_all("R10 grant ends on done", 0, 1, 0, '0);
    endtask

    task automatic t_reclaim();
        lend_bus();
        rf_req = 1'b1;
        mreq = 4'b0100;
        tick();
        chk_all("R5 ack dropped, still floating", 0, 0, 0, '0);
        tick();
        tick();
        chk_all("R5 floats until release", 0, 0, 0, '0);
        ext_req = 1'b0;
        tick();
        chk_all("R5 R4 recovered", 0, 1, 0, '0);
        ext_req = 1'b1;
        tick();
        chk_all("R7 refresh first", 0, 1, 1, '0);
        rf_done = 1'b1;
        rf_req = 1'b0;
        tick();
        rf_done = 1'b0;
        chk_all("R7 queued master next", 0, 1, 0, 4'b0100);
        adone = 1'b1;
        mreq = '0;
        tick();
        adone = 1'b0;
        chk_all("R7 lent after queue drains", 1, 0, 0, '0);
        ext_req = 1'b0;
        tick();
        tick();
        chk_all("R3 back to idle", 0, 1, 0, '0);
    endtask

    task automatic t_priority();
        rf_req = 1'b1;
        ext_req = 1'b1;
        mreq = 4'b0010;
        tick();
        chk_all("R8 refresh beats all", 0, 1, 1, '0);
        rf_done = 1'b1;
        rf_req = 1'b0;
        tick();
        rf_done = 1'b0;
        chk_all("R8 master beats external", 0, 1, 0, 4'b0010);
        adone = 1'b1;
        mreq = '0;
        tick();
        adone = 1'b0;
        chk_all("R8 external last", 1, 0, 0, '0);
        ext_req = 1'b0;
        tick();
        tick();
    endtask

    task automatic t_back_to_back();
        mreq = 4'b1010;
        tick();
        chk_all("R8 lowest index first", 0, 1, 0, 4'b0010);
        adone = 1'b1;
        mreq = 4'b1000;
        tick();
        adone = 1'b0;
        chk_all("R10 direct hand-over", 0, 1, 0, 4'b1000);
        adone = 1'b1;
        mreq = '0;
        tick();
        adone = 1'b0;
        chk_all("R10 all done", 0, 1, 0, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_pulse();
        t_lend_mst_ignored();
        t_reclaim();
        t_priority();
        t_back_to_back();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule